// File: doc/BRIEF.md
# Host Parallel MIDI Port

This block lets a host processor exchange MIDI bytes with an on-chip control processor over an 8-bit asynchronous register bus. The host side has an active-low select, active-low read and write strobes, one register-select line and a bidirectional data bus. The core side has two one-byte channels with valid/ready handshakes: one carries bytes from the host to the core, and the other carries bytes from the core to the host. An active-high interrupt tells the host that a byte is waiting.

The host pins are synchronized into the much faster internal clock. An access takes effect once, when its strobe is released. A host write with the select line low is a data byte. With the select line high it is a command byte, and the core sees the two kinds apart by a flag. A host read with the select line low returns the core-to-host data register. With the select line high it returns the status byte. Writes that arrive too soon after the previous accepted write are dropped, and so are writes that find the inbound slot still occupied.

Top module: `hmp_host_port`

## Requirements
- R1: After reset `host_irq` is 0, `h2c_valid` is 0, `c2h_ready` is 1 and a status read returns 0x80.
- R2: The port drives `host_data` only while `host_cs_n` and `host_rd_n` are both low. It drives the data register when `host_a0`=0 and the status byte when `host_a0`=1. At all other times the bus is high-impedance.
- R3: An accepted host write loads the inbound slot with the written byte. `h2c_is_cmd` equals the `host_a0` level of that write (0 = data, 1 = command).
- R4: Status bit 7 is 0 while a core-to-host byte waits unread. Status bit 6 is 1 while the inbound slot is occupied. Status bits 5..0 read 0.
- R5: `host_irq` is 1 exactly while a core-to-host byte waits. It clears after a host data read (`host_a0`=0) completes. A status read leaves it unchanged.
- R6: A host write that completes while the inbound slot is occupied is dropped, and the held byte is unchanged.
- R7: A host write that completes fewer than MIN_WR_GAP clocks (default 128) after the previous accepted write is dropped.
- R8: Each host access acts once, on the release of its strobe. It uses the bus and `host_a0` values that were present while the strobe was low.
- R9: The core-to-host slot takes a byte only while it is empty (`c2h_ready`=1). A byte offered while it is full is not taken.
- R10: A byte in the inbound slot stays on `h2c_data`/`h2c_is_cmd`, with `h2c_valid` high, until the core takes it with `h2c_ready`.
- R11: Strobes with `host_cs_n` high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_a0 | input | 1 | Register select: 0 data, 1 status/command |
| host_data | inout | 8 | Host data bus |
| host_irq | output | 1 | Interrupt, high while a byte waits for the host |
| h2c_valid | output | 1 | Inbound byte available to the core |
| h2c_ready | input | 1 | Core takes the inbound byte |
| h2c_data | output | 8 | Inbound byte |
| h2c_is_cmd | output | 1 | Inbound byte came from a command write |
| c2h_valid | input | 1 | Core offers an outbound byte |
| c2h_ready | output | 1 | Outbound slot is empty |
| c2h_data | input | 8 | Outbound byte |

## Verification
The bench targets the cases where a port loses or duplicates bytes. In the first, a second write lands inside the 128-clock window. A design without the rate limit would take that byte into the slot. In the second, a write finds the slot full. An overwriting design would replace the held byte. A status read made while the interrupt is pending checks that only data reads clear it, and a design decoding the select line wrongly would drop the pending byte. Strobes given with the chip select high, and a bus check with no read in progress, catch a port that decodes or drives without select.

// File: rtl/hmp_pkg.sv
package hmp_pkg;

    localparam int HOST_W      = 8;
    localparam int STAT_RX_BIT = 7;
    localparam int STAT_TX_BIT = 6;

    typedef logic [HOST_W-1:0] hbyte_t;

    // Raw host pin group, carried through the synchronizer as one vector.
    typedef struct packed {
        logic   cs_n;
        logic   rd_n;
        logic   wr_n;
        logic   a0;
        hbyte_t bus;
    } pin_bundle_t;

    localparam int PIN_W = $bits(pin_bundle_t);

    // Idle pin state: strobes and select released.
    localparam pin_bundle_t PIN_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                         a0: 1'b0, bus: '0};

    // One completed host access.
    typedef struct packed {
        logic   rd_done;
        logic   wr_done;
        logic   a0;
        hbyte_t val;
    } host_evt_t;

    // Word held in the inbound slot.
    typedef struct packed {
        logic   is_cmd;
        hbyte_t val;
    } h2c_word_t;

    localparam int H2C_W = $bits(h2c_word_t);

    function automatic hbyte_t make_status(logic c2h_full, logic h2c_full);
        hbyte_t s;
        s              = '0;
        s[STAT_RX_BIT] = ~c2h_full;
        s[STAT_TX_BIT] = h2c_full;
        return s;
    endfunction

endpackage

// File: rtl/hmp_sync.sv
module hmp_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= RST_VAL;
                    else     stg[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= RST_VAL;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/hmp_access_detect.sv
module hmp_access_detect
    import hmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pin_bundle_t pins,
    output host_evt_t   evt
);

    logic   rd_act, wr_act;
    logic   rd_prev, wr_prev;
    logic   cap_a0;
    hbyte_t cap_val;

    assign rd_act = ~pins.cs_n & ~pins.rd_n &  pins.wr_n;
    assign wr_act = ~pins.cs_n & ~pins.wr_n &  pins.rd_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_prev <= 1'b0;
            wr_prev <= 1'b0;
            cap_a0  <= 1'b0;
            cap_val <= '0;
        end else begin
            rd_prev <= rd_act;
            wr_prev <= wr_act;
            if (rd_act || wr_act) begin
                cap_a0  <= pins.a0;
                cap_val <= pins.bus;
            end
        end
    end

    always_comb begin
        evt.rd_done = rd_prev & ~rd_act;
        evt.wr_done = wr_prev & ~wr_act;
        evt.a0      = cap_a0;
        evt.val     = cap_val;
    end

    // R8: one event per strobe release
    a_r8_single_read_event: assert property (@(posedge clk) disable iff (rst)
        evt.rd_done |=> !evt.rd_done);
    a_r8_single_write_event: assert property (@(posedge clk) disable iff (rst)
        evt.wr_done |=> !evt.wr_done);
    a_r8_no_dual_event: assert property (@(posedge clk) disable iff (rst)
        !(evt.rd_done && evt.wr_done));

endmodule

// File: rtl/hmp_slot.sv
module hmp_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         full,
    output logic [W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (push) begin
                full <= 1'b1;
                data <= push_data;
            end else if (pop) begin
                full <= 1'b0;
            end
        end
    end

    // R6/R9: a push never lands on an occupied slot
    a_r6_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R10: contents held until taken
    a_r10_hold_until_pop: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> (full && $stable(data)));

endmodule

// File: rtl/hmp_gap_timer.sv
module hmp_gap_timer #(
    parameter int GAP = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    output logic open
);

    localparam int CW = $clog2(GAP + 1);

    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (rst)                     count <= CW'(GAP);
        else if (accept)             count <= '0;
        else if (count != CW'(GAP))  count <= count + 1'b1;
    end

    assign open = (count == CW'(GAP));

endmodule

// File: rtl/hmp_host_port.sv
module hmp_host_port
    import hmp_pkg::*;
#(
    parameter int MIN_WR_GAP  = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_cs_n,
    input  logic       host_rd_n,
    input  logic       host_wr_n,
    input  logic       host_a0,
    inout  wire  [7:0] host_data,
    output logic       host_irq,
    output logic       h2c_valid,
    input  logic       h2c_ready,
    output logic [7:0] h2c_data,
    output logic       h2c_is_cmd,
    input  logic       c2h_valid,
    output logic       c2h_ready,
    input  logic [7:0] c2h_data
);

    localparam int CW = $clog2(MIN_WR_GAP + 1);

    pin_bundle_t raw_pins, syn_pins;
    host_evt_t   evt;
    logic        gap_open;
    logic        wr_accept, rd_pop, c2h_push, h2c_pop;
    logic        h2c_full, c2h_full;
    h2c_word_t   h2c_in, h2c_q;
    hbyte_t      c2h_q, status, rd_value;
    logic        drive_en;

    always_comb begin
        raw_pins.cs_n = host_cs_n;
        raw_pins.rd_n = host_rd_n;
        raw_pins.wr_n = host_wr_n;
        raw_pins.a0   = host_a0;
        raw_pins.bus  = host_data;
    end

    hmp_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (syn_pins)
    );

    hmp_access_detect u_detect (
        .clk  (clk),
        .rst  (rst),
        .pins (syn_pins),
        .evt  (evt)
    );

    hmp_gap_timer #(.GAP(MIN_WR_GAP)) u_gap (
        .clk    (clk),
        .rst    (rst),
        .accept (wr_accept),
        .open   (gap_open)
    );

    assign wr_accept = evt.wr_done & gap_open & ~h2c_full;
    assign rd_pop    = evt.rd_done & ~evt.a0 & c2h_full;
    assign c2h_push  = c2h_valid & ~c2h_full;
    assign h2c_pop   = h2c_ready & h2c_full;

    always_comb begin
        h2c_in.is_cmd = evt.a0;
        h2c_in.val    = evt.val;
    end

    hmp_slot #(.W(H2C_W)) u_h2c (
        .clk       (clk),
        .rst       (rst),
        .push      (wr_accept),
        .push_data (h2c_in),
        .pop       (h2c_pop),
        .full      (h2c_full),
        .data      (h2c_q)
    );

    hmp_slot #(.W(HOST_W)) u_c2h (
        .clk       (clk),
        .rst       (rst),
        .push      (c2h_push),
        .push_data (c2h_data),
        .pop       (rd_pop),
        .full      (c2h_full),
        .data      (c2h_q)
    );

    assign h2c_valid  = h2c_full;
    assign h2c_data   = h2c_q.val;
    assign h2c_is_cmd = h2c_q.is_cmd;
    assign c2h_ready  = ~c2h_full;
    assign host_irq   = c2h_full;

    assign status    = make_status(c2h_full, h2c_full);
    assign rd_value  = host_a0 ? status : c2h_q;
    assign drive_en  = ~host_cs_n & ~host_rd_n;
    assign host_data = drive_en ? rd_value : 8'hzz;

    // Checker counter: clocks since the last accepted write
    logic [CW-1:0] since_acc;
    always_ff @(posedge clk) begin
        if (rst)                           since_acc <= CW'(MIN_WR_GAP);
        else if (wr_accept)                since_acc <= '0;
        else if (since_acc != CW'(MIN_WR_GAP)) since_acc <= since_acc + 1'b1;
    end

    // R7: accepted writes are spaced by the minimum gap
    a_r7_gap_respected: assert property (@(posedge clk) disable iff (rst)
        wr_accept |-> (since_acc == CW'(MIN_WR_GAP)));
    // R3: accepted write appears on the core side with its kind
    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_accept |=> (h2c_valid && (h2c_is_cmd == $past(evt.a0))));
    // R5: a data read of a waiting byte clears the interrupt
    a_r5_read_clears_irq: assert property (@(posedge clk) disable iff (rst)
        rd_pop |=> !host_irq);
    // R5: a status read leaves the interrupt alone
    a_r5_status_keeps_irq: assert property (@(posedge clk) disable iff (rst)
        (evt.rd_done && evt.a0 && host_irq) |=> host_irq);
    // R9: a byte taken from the core raises the interrupt
    a_r9_push_sets_irq: assert property (@(posedge clk) disable iff (rst)
        (c2h_valid && c2h_ready) |=> host_irq);

endmodule

// File: tb/hmp_host_port_test.sv
module hmp_host_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 128;

    localparam logic [2:0] OP_HWR0 = 3'd0;
    localparam logic [2:0] OP_HWR1 = 3'd1;
    localparam logic [2:0] OP_HRD0 = 3'd2;
    localparam logic [2:0] OP_HRD1 = 3'd3;
    localparam logic [2:0] OP_PUSH = 3'd4;
    localparam logic [2:0] OP_POP  = 3'd5;

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] val;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{op: OP_HRD1, val: 8'h00, exp: 8'h80},
        '{op: OP_HWR0, val: 8'h3C, exp: 8'h00},
        '{op: OP_HRD1, val: 8'h00, exp: 8'hC0},
        '{op: OP_POP,  val: 8'h00, exp: 8'h3C},
        '{op: OP_HWR1, val: 8'hA7, exp: 8'h00},
        '{op: OP_POP,  val: 8'h01, exp: 8'hA7},
        '{op: OP_PUSH, val: 8'h90, exp: 8'h00},
        '{op: OP_HRD1, val: 8'h00, exp: 8'h00},
        '{op: OP_HRD0, val: 8'h00, exp: 8'h90},
        '{op: OP_HRD1, val: 8'h00, exp: 8'h80},
        '{op: OP_PUSH, val: 8'hF7, exp: 8'h00},
        '{op: OP_HRD1, val: 8'h00, exp: 8'h00},
        '{op: OP_HRD0, val: 8'h00, exp: 8'hF7}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
    logic       tb_oe = 1'b0;
    logic [7:0] tb_dout = 8'h00;
    wire  [7:0] bus;
    logic       irq, h2c_valid, h2c_is_cmd, c2h_ready;
    logic       h2c_ready = 1'b0, c2h_valid = 1'b0;
    logic [7:0] h2c_data, c2h_data = 8'h00;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    assign bus = tb_oe ? tb_dout : 8'hzz;

    always #(CLK_PERIOD/2) clk = ~clk;

    hmp_host_port #(.MIN_WR_GAP(GAP), .SYNC_STAGES(2)) uut (
        .clk        (clk),
        .rst        (rst),
        .host_cs_n  (cs_n),
        .host_rd_n  (rd_n),
        .host_wr_n  (wr_n),
        .host_a0    (a0),
        .host_data  (bus),
        .host_irq   (irq),
        .h2c_valid  (h2c_valid),
        .h2c_ready  (h2c_ready),
        .h2c_data   (h2c_data),
        .h2c_is_cmd (h2c_is_cmd),
        .c2h_valid  (c2h_valid),
        .c2h_ready  (c2h_ready),
        .c2h_data   (c2h_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic sel, input logic [7:0] v);
        @(negedge clk);
        a0 = sel; cs_n = 1'b0; tb_oe = 1'b1; tb_dout = v;
        idle(2);
        wr_n = 1'b0;
        idle(4);
        wr_n = 1'b1; tb_oe = 1'b0; cs_n = 1'b1;
        idle(6);
    endtask

    task automatic host_read(input logic sel, output logic [7:0] v);
        @(negedge clk);
        a0 = sel; cs_n = 1'b0;
        idle(1);
        rd_n = 1'b0;
        idle(3);
        v = bus;
        rd_n = 1'b1; cs_n = 1'b1;
        idle(6);
    endtask

    task automatic core_push(input logic [7:0] v);
        @(negedge clk);
        c2h_valid = 1'b1; c2h_data = v;
        @(negedge clk);
        c2h_valid = 1'b0;
        idle(1);
    endtask

    task automatic core_pop(output logic v, output logic c, output logic [7:0] d);
        @(negedge clk);
        v = h2c_valid; c = h2c_is_cmd; d = h2c_data;
        h2c_ready = 1'b1;
        @(negedge clk);
        h2c_ready = 1'b0;
        idle(1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] rv, d;
        logic       v, c;

        idle(4);
        rst = 1'b0;
        idle(2);

        // R1: reset state
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 h2c_valid", {7'd0, h2c_valid}, 8'h00);
        check("R1 c2h_ready", {7'd0, c2h_ready}, 8'h01);

        // Table walk: R2/R4 reads, R3 writes and pops
        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                OP_HWR0: begin host_write(1'b0, VECS[i].val); idle(GAP + 10); end
                OP_HWR1: begin host_write(1'b1, VECS[i].val); idle(GAP + 10); end
                OP_HRD0: begin host_read(1'b0, rv); check("R2 data read", rv, VECS[i].exp); end
                OP_HRD1: begin host_read(1'b1, rv); check("R4 status read", rv, VECS[i].exp); end
                OP_PUSH: core_push(VECS[i].val);
                default: begin
                    core_pop(v, c, d);
                    check("R3 h2c_valid", {7'd0, v}, 8'h01);
                    check("R3 h2c_is_cmd", {7'd0, c}, {7'd0, VECS[i].val[0]});
                    check("R3 h2c_data", d, VECS[i].exp);
                end
            endcase
        end

        // R2: bus left to others when no read is in progress
        @(negedge clk);
        tb_oe = 1'b1; tb_dout = 8'hA5; cs_n = 1'b1; rd_n = 1'b0;
        idle(2);
        check("R2 bus released", bus, 8'hA5);
        rd_n = 1'b1; tb_oe = 1'b0;
        idle(2);

        // R11: write strobe without chip select
        @(negedge clk);
        a0 = 1'b0; tb_oe = 1'b1; tb_dout = 8'h5E;
        idle(2); wr_n = 1'b0; idle(4); wr_n = 1'b1; tb_oe = 1'b0;
        idle(8);
        check("R11 no write without select", {7'd0, h2c_valid}, 8'h00);

        // R5: interrupt set, kept by status read, cleared by data read
        core_push(8'h5A);
        check("R5 irq set", {7'd0, irq}, 8'h01);
        check("R9 ready low while full", {7'd0, c2h_ready}, 8'h00);
        core_push(8'h77);
        host_read(1'b1, rv);
        check("R4 status bit7", {7'd0, rv[7]}, 8'h00);
        check("R5 irq after status read", {7'd0, irq}, 8'h01);
        host_read(1'b0, rv);
        check("R9 first byte kept", rv, 8'h5A);
        check("R5 irq cleared", {7'd0, irq}, 8'h00);

        // R6: write into occupied slot dropped
        idle(GAP + 10);
        host_write(1'b0, 8'h11);
        idle(GAP + 10);
        host_write(1'b1, 8'h22);
        idle(40);
        // R10: held byte unchanged while not taken
        check("R10 held valid", {7'd0, h2c_valid}, 8'h01);
        check("R6 held data", h2c_data, 8'h11);
        check("R6 held kind", {7'd0, h2c_is_cmd}, 8'h00);
        core_pop(v, c, d);
        check("R6 popped", d, 8'h11);
        check("R6 slot empty", {7'd0, h2c_valid}, 8'h00);

        // R7: write inside the gap window dropped
        idle(GAP + 10);
        host_write(1'b0, 8'h33);
        core_pop(v, c, d);
        check("R8 captured byte", d, 8'h33);
        host_write(1'b0, 8'h44);
        idle(4);
        check("R7 early write dropped", {7'd0, h2c_valid}, 8'h00);
        idle(GAP + 10);
        host_write(1'b1, 8'h55);
        check("R7 late write accepted", {7'd0, h2c_valid}, 8'h01);
        check("R7 late write data", h2c_data, 8'h55);
        core_pop(v, c, d);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule